// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block runs one auxiliary-channel transfer from start to finish on behalf of a requester. It does this by starting a transaction engine again and again. After each engine completion it sorts the reported channel status and the reply code into one outcome. It then passes, fails, retries at once, or waits a fixed number of microseconds before the next attempt. Each kind of trouble has its own retry budget: channel timeout, malformed reply, short read, shared defer and downstream I2C defer. All attempts fall under one overall cap.

A requester pulses `req_valid` with the direction and byte length of the transfer. The sequencer then drives the engine through a start/done handshake. Microsecond waits are counted on a one-cycle `tick_us` strobe. The block ends by pulsing `done` for one cycle, with `pass` showing the result.

Top module: `aux_retry_seq`

## Requirements
- R1: After reset `busy`, `done` and `eng_start` are 0. A `req_valid` seen while idle starts a transfer, and `eng_start` pulses for exactly one cycle on the following cycle. `req_valid` has no effect while `busy` is 1.
- R2: A completion is sorted in a fixed priority. First, `eng_discon`=1 or `eng_complete`=0 fails the transfer at once. Next comes `eng_timeout`=1, then any bit of `eng_bad_frame` set. Last, `eng_rx_count`=0 counts as a malformed reply.
- R3: A timeout starts the next attempt with no wait. The third timeout without an intervening successful completion fails the transfer.
- R4: A malformed reply waits `WAIT_INVALID_US` (400) ticks of `tick_us` before the next attempt. The second one fails the transfer.
- R5: Any completion that reaches reply-code decoding clears both the timeout and malformed-reply counts.
- R6: Reply code 0 (acknowledge) passes a write, and passes a read whose payload count (`eng_rx_count`−1) equals `req_len`. Any other read with code 0 is a short read: it waits 300 ticks and retries, and the seventh short read fails.
- R7: Reply codes 2 (native defer), 4 (bridged I2C no-acknowledge) and 8 (bridged I2C defer) retry at once and share one counter that fails at 7.
- R8: Reply code 3 (downstream I2C defer) clears the shared defer counter, retries at once, and has its own counter that fails at 7.
- R9: Reply code 1 (native no-acknowledge) and any code not listed above fail the transfer at once.
- R10: No more than 7 attempts are started per transfer. An outcome that would retry after the seventh attempt fails instead.
- R11: `done` is high for exactly one cycle per transfer and `busy` is 0 on the next cycle. `pass` is 1 only during `done`, and only for a passing transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transfer (sampled while idle) |
| req_read | input | 1 | 1 for a read transfer, 0 for a write |
| req_len | input | LEN_W | Requested payload byte count |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| eng_start | output | 1 | One-cycle start pulse to the transaction engine |
| eng_done | input | 1 | Engine completion strobe |
| eng_discon | input | 1 | Sink disconnected during the attempt |
| eng_complete | input | 1 | Engine reports a finished transaction |
| eng_timeout | input | 1 | Reply timeout seen |
| eng_bad_frame | input | 4 | Malformed reply indications (any set = malformed) |
| eng_rx_count | input | LEN_W+1 | Received bytes including the reply-code byte |
| eng_reply | input | 4 | Reply code of the attempt |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| pass | output | 1 | Result, valid while done is 1 |

## Verification
The engine stub replays scripted completions. The scripts are single clean acknowledges for reads and writes, and short-then-full reads. They also include runs of timeouts and of malformed replies, and completions that carry several status flags at once. Some runs mix defer codes or interleave failure kinds with successful completions. The flag combinations tell the status priority apart: timeout plus malformed fails at three, not two. The interleaved runs show whether counters are cleared selectively, and a seventh-attempt run shows the overall cap taking over from a per-cause budget. A cycle-level model also checks backoff lengths against the tick strobe, and a stray request mid-transfer must leave the sequence untouched.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

    typedef enum logic [2:0] {
        OC_PASS,
        OC_SHORT,
        OC_DEFER,
        OC_I2C_DEFER,
        OC_TIMEOUT,
        OC_INVALID,
        OC_FATAL
    } outcome_e;

    typedef enum logic [1:0] {
        DC_PASS,
        DC_FAIL,
        DC_RETRY,
        DC_WAIT
    } decision_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_BACKOFF,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic       discon;
        logic       complete;
        logic       timeout;
        logic [3:0] bad_frame;
    } chan_status_t;

    localparam logic [3:0] RC_ACK       = 4'd0;
    localparam logic [3:0] RC_NACK      = 4'd1;
    localparam logic [3:0] RC_DEFER     = 4'd2;
    localparam logic [3:0] RC_I2C_DEFER = 4'd3;
    localparam logic [3:0] RC_BR_NACK   = 4'd4;
    localparam logic [3:0] RC_BR_DEFER  = 4'd8;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // True when one more occurrence uses up the budget
    function automatic logic spent(input int cnt, input int lim);
        return (cnt + 1) >= lim;
    endfunction

endpackage

// File: rtl/aux_outcome_classify.sv
module aux_outcome_classify
    import aux_retry_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  chan_status_t     st,
    input  logic [LEN_W:0]   rx_count,
    input  logic [3:0]       reply,
    input  logic             is_read,
    input  logic [LEN_W-1:0] want_len,
    output outcome_e         outcome
);

    logic [LEN_W:0] payload_bytes;
    assign payload_bytes = rx_count - {{LEN_W{1'b0}}, 1'b1};

    always_comb begin
        if (st.discon || !st.complete) begin
            outcome = OC_FATAL;
        end else if (st.timeout) begin
            outcome = OC_TIMEOUT;
        end else if ((|st.bad_frame) || (rx_count == '0)) begin
            outcome = OC_INVALID;
        end else begin
            case (reply)
                RC_ACK:       outcome = (is_read && (payload_bytes != {1'b0, want_len}))
                                        ? OC_SHORT : OC_PASS;
                RC_DEFER,
                RC_BR_NACK,
                RC_BR_DEFER:  outcome = OC_DEFER;
                RC_I2C_DEFER: outcome = OC_I2C_DEFER;
                default:      outcome = OC_FATAL;
            endcase
        end
    end

endmodule

// File: rtl/aux_retry_budget.sv
module aux_retry_budget
    import aux_retry_pkg::*;
#(
    parameter int MAX_ATTEMPTS    = 7,
    parameter int LIM_TIMEOUT     = 3,
    parameter int LIM_INVALID     = 2,
    parameter int LIM_SHORT       = 7,
    parameter int LIM_DEFER       = 7,
    parameter int LIM_I2C_DEFER   = 7,
    parameter int WAIT_INVALID_US = 400,
    parameter int WAIT_SHORT_US   = 300,
    parameter int CNT_W           = 4,
    parameter int WAIT_W          = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              attempt_inc,
    input  logic              judge,
    input  outcome_e          outcome,
    output decision_e         decision,
    output logic [WAIT_W-1:0] wait_us
);

    localparam decision_e INV_STEP   = (WAIT_INVALID_US == 0) ? DC_RETRY : DC_WAIT;
    localparam decision_e SHORT_STEP = (WAIT_SHORT_US == 0) ? DC_RETRY : DC_WAIT;

    logic [CNT_W-1:0] att_q, to_q, inv_q, sh_q, df_q, i2_q;
    logic             cap_hit;

    assign cap_hit = int'(att_q) >= MAX_ATTEMPTS;

    always_comb begin
        wait_us  = '0;
        decision = DC_FAIL;
        case (outcome)
            OC_PASS:      decision = DC_PASS;
            OC_TIMEOUT:   decision = (spent(int'(to_q), LIM_TIMEOUT) || cap_hit) ? DC_FAIL : DC_RETRY;
            OC_INVALID: begin
                decision = (spent(int'(inv_q), LIM_INVALID) || cap_hit) ? DC_FAIL : INV_STEP;
                wait_us  = WAIT_W'(WAIT_INVALID_US);
            end
            OC_SHORT: begin
                decision = (spent(int'(sh_q), LIM_SHORT) || cap_hit) ? DC_FAIL : SHORT_STEP;
                wait_us  = WAIT_W'(WAIT_SHORT_US);
            end
            OC_DEFER:     decision = (spent(int'(df_q), LIM_DEFER) || cap_hit) ? DC_FAIL : DC_RETRY;
            OC_I2C_DEFER: decision = (spent(int'(i2_q), LIM_I2C_DEFER) || cap_hit) ? DC_FAIL : DC_RETRY;
            default:      decision = DC_FAIL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            att_q <= '0;
            to_q  <= '0;
            inv_q <= '0;
            sh_q  <= '0;
            df_q  <= '0;
            i2_q  <= '0;
        end else begin
            if (attempt_inc) begin
                att_q <= att_q + 1'b1;
            end
            if (judge) begin
                case (outcome)
                    OC_TIMEOUT: to_q  <= to_q + 1'b1;
                    OC_INVALID: inv_q <= inv_q + 1'b1;
                    OC_FATAL: ;
                    default: begin
                        to_q  <= '0;
                        inv_q <= '0;
                    end
                endcase
                case (outcome)
                    OC_SHORT:     sh_q <= sh_q + 1'b1;
                    OC_DEFER:     df_q <= df_q + 1'b1;
                    OC_I2C_DEFER: begin
                        df_q <= '0;
                        i2_q <= i2_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(att_q) <= MAX_ATTEMPTS);                                       // R10
    AST_TIMEOUT_BUDGET: assert property (@(posedge clk) disable iff (rst)
        int'(to_q) <= LIM_TIMEOUT);                                         // R3
    AST_INVALID_BUDGET: assert property (@(posedge clk) disable iff (rst)
        int'(inv_q) <= LIM_INVALID);                                        // R4

endmodule

// File: rtl/aux_backoff_timer.sv
module aux_backoff_timer #(
    parameter int WAIT_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              tick,
    output logic              expire
);

    logic [WAIT_W-1:0] cnt_q;

    assign expire = tick && (cnt_q == WAIT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/aux_retry_seq.sv
module aux_retry_seq
    import aux_retry_pkg::*;
#(
    parameter int LEN_W           = 8,
    parameter int MAX_ATTEMPTS    = 7,
    parameter int LIM_TIMEOUT     = 3,
    parameter int LIM_INVALID     = 2,
    parameter int LIM_SHORT       = 7,
    parameter int LIM_DEFER       = 7,
    parameter int LIM_I2C_DEFER   = 7,
    parameter int WAIT_INVALID_US = 400,
    parameter int WAIT_SHORT_US   = 300
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [LEN_W-1:0] req_len,
    input  logic             tick_us,
    output logic             eng_start,
    input  logic             eng_done,
    input  logic             eng_discon,
    input  logic             eng_complete,
    input  logic             eng_timeout,
    input  logic [3:0]       eng_bad_frame,
    input  logic [LEN_W:0]   eng_rx_count,
    input  logic [3:0]       eng_reply,
    output logic             busy,
    output logic             done,
    output logic             pass
);

    localparam int LIM_TOP = max_of(MAX_ATTEMPTS, max_of(max_of(LIM_TIMEOUT, LIM_INVALID),
                                    max_of(LIM_SHORT, max_of(LIM_DEFER, LIM_I2C_DEFER))));
    localparam int CNT_W   = $clog2(LIM_TOP + 1);
    localparam int WAIT_W  = $clog2(max_of(WAIT_INVALID_US, WAIT_SHORT_US) + 1) + 1;

    seq_state_e        state_q;
    logic              read_q;
    logic [LEN_W-1:0]  len_q;
    logic              pass_q;
    chan_status_t      status;
    outcome_e          outcome;
    decision_e         decision;
    logic [WAIT_W-1:0] wait_us;
    logic              start_req, judge, load_wait, wait_over;

    assign status    = '{discon: eng_discon, complete: eng_complete,
                         timeout: eng_timeout, bad_frame: eng_bad_frame};
    assign start_req = (state_q == ST_IDLE) && req_valid;
    assign judge     = (state_q == ST_WAIT) && eng_done;
    assign load_wait = judge && (decision == DC_WAIT);

    aux_outcome_classify #(.LEN_W(LEN_W)) u_classify (
        .st       (status),
        .rx_count (eng_rx_count),
        .reply    (eng_reply),
        .is_read  (read_q),
        .want_len (len_q),
        .outcome  (outcome)
    );

    aux_retry_budget #(
        .MAX_ATTEMPTS    (MAX_ATTEMPTS),
        .LIM_TIMEOUT     (LIM_TIMEOUT),
        .LIM_INVALID     (LIM_INVALID),
        .LIM_SHORT       (LIM_SHORT),
        .LIM_DEFER       (LIM_DEFER),
        .LIM_I2C_DEFER   (LIM_I2C_DEFER),
        .WAIT_INVALID_US (WAIT_INVALID_US),
        .WAIT_SHORT_US   (WAIT_SHORT_US),
        .CNT_W           (CNT_W),
        .WAIT_W          (WAIT_W)
    ) u_budget (
        .clk         (clk),
        .rst         (rst),
        .clear       (start_req),
        .attempt_inc (state_q == ST_ISSUE),
        .judge       (judge),
        .outcome     (outcome),
        .decision    (decision),
        .wait_us     (wait_us)
    );

    aux_backoff_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load_wait),
        .load_val (wait_us),
        .tick     (tick_us),
        .expire   (wait_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            read_q  <= 1'b0;
            len_q   <= '0;
            pass_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    read_q  <= req_read;
                    len_q   <= req_len;
                    pass_q  <= 1'b0;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (eng_done) begin
                    case (decision)
                        DC_PASS:  begin pass_q <= 1'b1; state_q <= ST_FIN; end
                        DC_FAIL:  begin pass_q <= 1'b0; state_q <= ST_FIN; end
                        DC_RETRY: state_q <= ST_ISSUE;
                        default:  state_q <= ST_BACKOFF;
                    endcase
                end
                ST_BACKOFF: if (wait_over) state_q <= ST_ISSUE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign eng_start = (state_q == ST_ISSUE);
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign pass      = done && pass_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);                                          // R1
    AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_start);                                              // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));                                         // R11
    AST_DISCON_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && eng_done && eng_discon) |=> (done && !pass)); // R2
    AST_PASS_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);                                                     // R11

endmodule

// File: tb/aux_retry_seq_bench.sv
module aux_retry_seq_bench;

    typedef struct packed {
        logic       discon;
        logic       complete;
        logic       timeout;
        logic [3:0] bad;
        logic [8:0] cnt;
        logic [3:0] code;
    } resp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_read = 1'b0;
    logic [7:0] req_len = '0;
    logic       tick_us = 1'b0;
    logic       eng_start;
    logic       eng_done = 1'b0;
    logic       eng_discon = 1'b0;
    logic       eng_complete = 1'b0;
    logic       eng_timeout = 1'b0;
    logic [3:0] eng_bad_frame = '0;
    logic [8:0] eng_rx_count = '0;
    logic [3:0] eng_reply = '0;
    logic       busy, done, pass;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int att_seen = 0;
    int pend = 0;
    resp_t rq[$];

    always #10 clk = ~clk;

    aux_retry_seq u_aux_retry_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
        .req_len(req_len), .tick_us(tick_us), .eng_start(eng_start),
        .eng_done(eng_done), .eng_discon(eng_discon), .eng_complete(eng_complete),
        .eng_timeout(eng_timeout), .eng_bad_frame(eng_bad_frame),
        .eng_rx_count(eng_rx_count), .eng_reply(eng_reply),
        .busy(busy), .done(done), .pass(pass)
    );

    function automatic resp_t r_code(input int code, input int cnt);
        return '{discon: 1'b0, complete: 1'b1, timeout: 1'b0, bad: 4'd0,
                 cnt: 9'(cnt), code: 4'(code)};
    endfunction
    function automatic resp_t r_to();
        resp_t r = r_code(0, 1); r.timeout = 1'b1; return r;
    endfunction
    function automatic resp_t r_inv();
        resp_t r = r_code(0, 1); r.bad = 4'b0100; return r;
    endfunction

    // ---------------- behavioural reference model ----------------
    int m_st = 0;            // 0 idle, 1 start, 2 wait engine, 3 backoff, 4 finish
    int m_w = 0, m_att = 0, m_to = 0, m_inv = 0, m_sh = 0, m_df = 0, m_i2 = 0;
    int m_len = 0;
    bit m_read = 0, m_pass = 0;

    task automatic m_end(input bit ok);
        m_pass = ok; m_st = 4;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pass = 0;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    m_read = req_read; m_len = int'(req_len);
                    m_att = 0; m_to = 0; m_inv = 0; m_sh = 0; m_df = 0; m_i2 = 0;
                    m_st = 1;
                end
                1: begin m_att++; m_st = 2; end
                2: if (eng_done) begin
                    if (eng_discon || !eng_complete) m_end(0);
                    else if (eng_timeout) begin
                        m_to++;
                        if (m_to >= 3 || m_att >= 7) m_end(0); else m_st = 1;
                    end else if (eng_bad_frame != 0 || eng_rx_count == 0) begin
                        m_inv++;
                        if (m_inv >= 2 || m_att >= 7) m_end(0); else begin m_w = 400; m_st = 3; end
                    end else begin
                        m_to = 0; m_inv = 0;
                        case (int'(eng_reply))
                            0: if (m_read && int'(eng_rx_count) - 1 != m_len) begin
                                   m_sh++;
                                   if (m_sh >= 7 || m_att >= 7) m_end(0); else begin m_w = 300; m_st = 3; end
                               end else m_end(1);
                            2, 4, 8: begin
                                m_df++;
                                if (m_df >= 7 || m_att >= 7) m_end(0); else m_st = 1;
                            end
                            3: begin
                                m_df = 0; m_i2++;
                                if (m_i2 >= 7 || m_att >= 7) m_end(0); else m_st = 1;
                            end
                            default: m_end(0);
                        endcase
                    end
                end
                3: if (tick_us) begin
                    if (m_w == 1) m_st = 1; else m_w--;
                end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (busy !== (m_st != 0) || eng_start !== (m_st == 1) ||
                done !== (m_st == 4) || pass !== (m_st == 4 && m_pass)) begin
                fails++;
                $display("FAIL R1/R11 cycle %0d: actual busy=%b start=%b done=%b pass=%b expected busy=%b start=%b done=%b pass=%b",
                         cyc, busy, eng_start, done, pass, m_st != 0, m_st == 1, m_st == 4, m_st == 4 && m_pass);
            end
            if (eng_start) att_seen++;
        end
    end

    // tick generator: high on every other cycle
    always @(negedge clk) tick_us = ~tick_us;

    // engine stub: completes three cycles after each start
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                resp_t r;
                r = (rq.size() > 0) ? rq.pop_front()
                                    : '{discon: 1'b1, complete: 1'b1, timeout: 1'b0, bad: 4'd0, cnt: 9'd0, code: 4'd0};
                eng_discon = r.discon; eng_complete = r.complete; eng_timeout = r.timeout;
                eng_bad_frame = r.bad; eng_rx_count = r.cnt; eng_reply = r.code;
                eng_done = 1'b1;
            end
        end
        if (eng_start) pend = 3;
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit rd, input int len, input int exp_att,
                           input bit exp_pass, input string tag, input bit poke);
        int n;
        att_seen = 0;
        @(negedge clk);
        req_read = rd; req_len = 8'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (done !== 1'b1) begin
            @(negedge clk);
            n++;
            if (poke) req_valid = (n == 30);
        end
        req_valid = 1'b0;
        check({tag, " pass"}, int'(pass), int'(exp_pass));
        check({tag, " attempts"}, att_seen, exp_att);
        check({tag, " script used"}, rq.size(), 0);
        rq.delete();
        repeat (3) @(negedge clk);
        check({tag, " idle after"}, int'(busy), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL R11 watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        resp_t r;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset start", int'(eng_start), 0);

        rq.push_back(r_code(0, 1));
        run_txn(0, 2, 1, 1, "R6 write ack", 0);
        rq.push_back(r_code(0, 5));
        run_txn(1, 4, 1, 1, "R6 read full", 0);
        rq.push_back(r_code(0, 3)); rq.push_back(r_code(0, 5));
        run_txn(1, 4, 2, 1, "R6 short then full", 0);

        repeat (3) rq.push_back(r_to());
        run_txn(0, 1, 3, 0, "R3 three timeouts", 0);
        rq.push_back(r_to()); rq.push_back(r_to()); rq.push_back(r_code(2, 1));
        rq.push_back(r_to()); rq.push_back(r_to()); rq.push_back(r_code(0, 1));
        run_txn(0, 1, 6, 1, "R5 timeouts cleared by defer", 0);

        rq.push_back(r_inv()); rq.push_back(r_inv());
        run_txn(0, 1, 2, 0, "R4 two malformed", 1);   // also R1 ignored request
        rq.push_back(r_inv()); rq.push_back(r_code(4, 1));
        rq.push_back(r_inv()); rq.push_back(r_code(0, 1));
        run_txn(0, 1, 4, 1, "R5 malformed cleared", 0);

        r = r_to(); r.discon = 1'b1; rq.push_back(r);
        run_txn(0, 1, 1, 0, "R2 disconnect first", 0);
        r = r_code(0, 1); r.complete = 1'b0; rq.push_back(r);
        run_txn(0, 1, 1, 0, "R2 not complete", 0);
        r = r_to(); r.bad = 4'b1001;
        repeat (3) rq.push_back(r);
        run_txn(0, 1, 3, 0, "R2 timeout over malformed", 0);
        repeat (2) rq.push_back(r_code(0, 0));
        run_txn(0, 1, 2, 0, "R2 zero count malformed", 0);

        rq.push_back(r_code(2, 1)); rq.push_back(r_code(4, 1)); rq.push_back(r_code(8, 1));
        rq.push_back(r_code(2, 1)); rq.push_back(r_code(4, 1)); rq.push_back(r_code(8, 1));
        rq.push_back(r_code(2, 1));
        run_txn(0, 1, 7, 0, "R7 shared defer", 0);
        repeat (3) rq.push_back(r_code(2, 1));
        rq.push_back(r_code(3, 1));
        repeat (2) rq.push_back(r_code(2, 1));
        rq.push_back(r_code(0, 1));
        run_txn(0, 1, 7, 1, "R8 mixed defers", 0);
        repeat (7) rq.push_back(r_code(3, 1));
        run_txn(0, 1, 7, 0, "R8 i2c defer budget", 0);

        rq.push_back(r_code(1, 1));
        run_txn(0, 1, 1, 0, "R9 native nack", 0);
        rq.push_back(r_code(5, 1));
        run_txn(0, 1, 1, 0, "R9 unknown code", 0);

        repeat (3) begin rq.push_back(r_to()); rq.push_back(r_code(8, 1)); end
        rq.push_back(r_to());
        run_txn(0, 1, 7, 0, "R10 attempt cap", 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule